// File: doc/BRIEF.md
# Bundle Register Renamer

This block renames up to four instructions in one clock for an out-of-order core. Each slot carries two architectural source registers and an optional architectural destination. For every slot that writes a register, the renamer takes one physical register from the free list. It maps each source to the physical register that holds, or will hold, its value. It reports the physical register that held the destination's previous value, so that register can be released later. In the same clock it updates its speculative map table.

A source normally reads the map table. When an earlier slot in the same bundle writes that source, the source instead takes the physical register just reserved for the nearest such slot. If there are too few free registers for all writers in the bundle, the whole bundle stalls and nothing changes. A flush input loads a committed map, supplied from outside, into the speculative map in one cycle so the core can recover from misspeculation. Architectural register 0 is never renamed.

Top module: `bundle_renamer`

## Requirements
- R1: After reset, every architectural register k maps to physical register k. A source naming register k renames to k until a bundle writes k.
- R2: If the number of writing slots exceeds `fl_avail_i`, then `stall_o` is 1 and `fl_pop_o` is 0, and the map table is left unchanged.
- R3: A writing slot is one with valid set, has-destination set and a destination other than 0. Writing slot number n, counted in slot order from 0, receives `fl_free_i[n]` on `ren_dst_o`. `fl_pop_o` equals the number of writing slots when the bundle is accepted.
- R4: A source whose register no earlier slot of the bundle writes takes the map table's current entry for that register.
- R5: A source written by one or more earlier slots of the bundle takes the new physical register of the nearest earlier writer.
- R6: After a bundle is accepted, the next cycle sees every written register mapped to its new physical register.
- R7: When several slots write the same register, the map keeps the last writer's physical register. Each later writer reports the previous writer's new register on `ren_old_o`.
- R8: A writing slot with no earlier writer of the same register reports, on `ren_old_o`, the map entry held before the bundle.
- R9: Source register 0 always renames to physical 0. A destination of 0 consumes no free register and leaves the map unchanged.
- R10: While `flush_i` is 1, `stall_o` is 1 and `fl_pop_o` is 0. On the next cycle, the map equals `cmt_map_i`, with entry 0 forced to 0, and the bundle presented during the flush has had no effect.
- R11: A slot with valid clear consumes no free register and does not change the map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Load the committed map into the speculative map |
| cmt_map_i | input | 32x6 | Committed map, one physical number per architectural register |
| slot_vld_i | input | 4 | Per-slot valid |
| slot_src1_i | input | 4x5 | First architectural source per slot |
| slot_src2_i | input | 4x5 | Second architectural source per slot |
| slot_dst_i | input | 4x5 | Architectural destination per slot |
| slot_hasdst_i | input | 4 | Per-slot has-destination |
| fl_free_i | input | 4x6 | Next free physical registers; entry 0 is taken first |
| fl_avail_i | input | 3 | Number of valid entries in `fl_free_i` |
| fl_pop_o | output | 3 | Number of free entries consumed this cycle |
| stall_o | output | 1 | Bundle not accepted this cycle |
| ren_src1_o | output | 4x6 | Renamed first source per slot |
| ren_src2_o | output | 4x6 | Renamed second source per slot |
| ren_dst_o | output | 4x6 | New physical destination per slot (0 when the slot does not write) |
| ren_old_o | output | 4x6 | Previous physical mapping of each slot's destination |

## Verification
The assertions take for granted that the free-list entries offered in one cycle are distinct and never physical 0. They also take for granted that `fl_avail_i` never exceeds the slot count. The bench always supplies a run of consecutive, distinct, non-zero register numbers and a count within range. Its flush test drives a committed map whose entries all lie inside the physical range. The bundles are hand-built to exercise repeated destinations, chains of forwarding, destination 0, invalid slots and shortage of free registers. They cover each case one at a time.

// File: rtl/rnm_pkg.sv
// Package: default sizing shared by the renamer and its checker.
// Assumes: the physical register count is at least the architectural count.
package rnm_pkg;
    localparam int DEF_SLOTS = 4;
    localparam int DEF_ARCH  = 32;
    localparam int DEF_PHYS  = 64;
endpackage

// File: rtl/rnm_alloc.sv
// rnm_alloc: marks the slots that write a register and hands each one the
// next free-list entry in slot order; also reports shortage.
// Assumes: SLOTS >= 2 and free entries are distinct.
module rnm_alloc #(
    parameter int SLOTS  = rnm_pkg::DEF_SLOTS,
    parameter int ARCH_W = 5,
    parameter int PHYS_W = 6,
    parameter int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0]             vld_i,
    input  logic [SLOTS-1:0]             hasdst_i,
    input  logic [SLOTS-1:0][ARCH_W-1:0] dst_i,
    input  logic [SLOTS-1:0][PHYS_W-1:0] free_i,
    input  logic [CNT_W-1:0]             avail_i,
    output logic [SLOTS-1:0]             wr_o,
    output logic [SLOTS-1:0][PHYS_W-1:0] new_o,
    output logic [CNT_W-1:0]             need_o,
    output logic                         short_o
);
    localparam int IDX_W = $clog2(SLOTS);

    logic [CNT_W-1:0] cnt;

    // Walk the slots in order, giving each writer the next free entry.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            wr_o[i]  = vld_i[i] && hasdst_i[i] && (dst_i[i] != '0);
            new_o[i] = '0;
            if (wr_o[i]) begin
                new_o[i] = free_i[cnt[IDX_W-1:0]];
                cnt      = cnt + 1'b1;
            end
        end
        need_o  = cnt;
        short_o = (cnt > avail_i);
    end
endmodule

// File: rtl/rnm_fwd.sv
// rnm_fwd: resolves dependences inside the bundle. Each source and each
// destination's old mapping takes the new register of the nearest earlier
// writer of the same architectural register, else the map table value.
// Assumes: wr_i is never set for architectural register 0.
module rnm_fwd #(
    parameter int SLOTS  = rnm_pkg::DEF_SLOTS,
    parameter int ARCH_W = 5,
    parameter int PHYS_W = 6
) (
    input  logic [SLOTS-1:0]             wr_i,
    input  logic [SLOTS-1:0][ARCH_W-1:0] dst_i,
    input  logic [SLOTS-1:0][PHYS_W-1:0] new_i,
    input  logic [SLOTS-1:0][ARCH_W-1:0] src1_i,
    input  logic [SLOTS-1:0][ARCH_W-1:0] src2_i,
    input  logic [SLOTS-1:0][PHYS_W-1:0] map_src1_i,
    input  logic [SLOTS-1:0][PHYS_W-1:0] map_src2_i,
    input  logic [SLOTS-1:0][PHYS_W-1:0] map_dst_i,
    output logic [SLOTS-1:0][PHYS_W-1:0] src1_o,
    output logic [SLOTS-1:0][PHYS_W-1:0] src2_o,
    output logic [SLOTS-1:0][PHYS_W-1:0] old_o
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        // Scan earlier slots in ascending order so the nearest writer wins.
        always_comb begin
            src1_o[i] = map_src1_i[i];
            src2_o[i] = map_src2_i[i];
            old_o[i]  = map_dst_i[i];
            for (int j = 0; j < i; j++) begin
                if (wr_i[j] && dst_i[j] == src1_i[i]) src1_o[i] = new_i[j];
                if (wr_i[j] && dst_i[j] == src2_i[i]) src2_o[i] = new_i[j];
                if (wr_i[j] && dst_i[j] == dst_i[i])  old_o[i]  = new_i[j];
            end
        end
    end
endmodule

// File: rtl/rnm_map_table.sv
// rnm_map_table: speculative architectural-to-physical map with read ports,
// ordered per-slot writes (later slot wins) and a one-cycle flush load.
// Assumes: NUM_PHYS >= NUM_ARCH so the reset identity map fits.
module rnm_map_table #(
    parameter int SLOTS    = rnm_pkg::DEF_SLOTS,
    parameter int NUM_ARCH = rnm_pkg::DEF_ARCH,
    parameter int NUM_RD   = 3 * SLOTS,
    parameter int ARCH_W   = $clog2(NUM_ARCH),
    parameter int PHYS_W   = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            flush_i,
    input  logic [NUM_ARCH-1:0][PHYS_W-1:0] cmt_map_i,
    input  logic [SLOTS-1:0]                we_i,
    input  logic [SLOTS-1:0][ARCH_W-1:0]    wa_i,
    input  logic [SLOTS-1:0][PHYS_W-1:0]    wd_i,
    input  logic [NUM_RD-1:0][ARCH_W-1:0]   ra_i,
    output logic [NUM_RD-1:0][PHYS_W-1:0]   rd_o
);
    logic [NUM_ARCH-1:0][PHYS_W-1:0] map_q;

    // Reset to identity, load on flush, otherwise apply writes in slot order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= PHYS_W'(a);
        end else if (flush_i) begin
            map_q    <= cmt_map_i;
            map_q[0] <= '0;
        end else begin
            for (int s = 0; s < SLOTS; s++)
                if (we_i[s]) map_q[wa_i[s]] <= wd_i[s];
        end
    end

    // Combinational read ports.
    always_comb begin
        for (int p = 0; p < NUM_RD; p++) rd_o[p] = map_q[ra_i[p]];
    end
endmodule

// File: rtl/bundle_renamer.sv
// bundle_renamer: top level. Allocates, forwards and updates the map for one
// bundle per clock; stalls the whole bundle on free-list shortage or flush.
// Assumes: free entries offered are distinct and non-zero.
module bundle_renamer #(
    parameter int SLOTS    = rnm_pkg::DEF_SLOTS,
    parameter int NUM_ARCH = rnm_pkg::DEF_ARCH,
    parameter int NUM_PHYS = rnm_pkg::DEF_PHYS,
    parameter int ARCH_W   = $clog2(NUM_ARCH),
    parameter int PHYS_W   = $clog2(NUM_PHYS),
    parameter int CNT_W    = $clog2(SLOTS + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            flush_i,
    input  logic [NUM_ARCH-1:0][PHYS_W-1:0] cmt_map_i,
    input  logic [SLOTS-1:0]                slot_vld_i,
    input  logic [SLOTS-1:0][ARCH_W-1:0]    slot_src1_i,
    input  logic [SLOTS-1:0][ARCH_W-1:0]    slot_src2_i,
    input  logic [SLOTS-1:0][ARCH_W-1:0]    slot_dst_i,
    input  logic [SLOTS-1:0]                slot_hasdst_i,
    input  logic [SLOTS-1:0][PHYS_W-1:0]    fl_free_i,
    input  logic [CNT_W-1:0]                fl_avail_i,
    output logic [CNT_W-1:0]                fl_pop_o,
    output logic                            stall_o,
    output logic [SLOTS-1:0][PHYS_W-1:0]    ren_src1_o,
    output logic [SLOTS-1:0][PHYS_W-1:0]    ren_src2_o,
    output logic [SLOTS-1:0][PHYS_W-1:0]    ren_dst_o,
    output logic [SLOTS-1:0][PHYS_W-1:0]    ren_old_o
);
    localparam int NUM_RD = 3 * SLOTS;

    logic [SLOTS-1:0]               wr;
    logic [SLOTS-1:0][PHYS_W-1:0]   new_preg;
    logic [CNT_W-1:0]               need;
    logic                           short_fl;
    logic                           accept;
    logic [NUM_RD-1:0][ARCH_W-1:0]  rd_addr;
    logic [NUM_RD-1:0][PHYS_W-1:0]  rd_data;
    logic [SLOTS-1:0][PHYS_W-1:0]   m_src1, m_src2, m_dst;

    rnm_alloc #(.SLOTS(SLOTS), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W), .CNT_W(CNT_W)) alloc_i (
        .vld_i(slot_vld_i), .hasdst_i(slot_hasdst_i), .dst_i(slot_dst_i),
        .free_i(fl_free_i), .avail_i(fl_avail_i),
        .wr_o(wr), .new_o(new_preg), .need_o(need), .short_o(short_fl)
    );

    // Bundle goes through only with enough free registers and no flush.
    always_comb begin
        accept   = !flush_i && !short_fl;
        stall_o  = !accept;
        fl_pop_o = accept ? need : '0;
    end

    // Lay out read ports: sources first, then destinations (old mapping).
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            rd_addr[s]           = slot_src1_i[s];
            rd_addr[SLOTS + s]   = slot_src2_i[s];
            rd_addr[2*SLOTS + s] = slot_dst_i[s];
            m_src1[s] = rd_data[s];
            m_src2[s] = rd_data[SLOTS + s];
            m_dst[s]  = rd_data[2*SLOTS + s];
        end
    end

    rnm_map_table #(.SLOTS(SLOTS), .NUM_ARCH(NUM_ARCH), .NUM_RD(NUM_RD),
                    .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)) map_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .cmt_map_i(cmt_map_i),
        .we_i(wr & {SLOTS{accept}}), .wa_i(slot_dst_i), .wd_i(new_preg),
        .ra_i(rd_addr), .rd_o(rd_data)
    );

    rnm_fwd #(.SLOTS(SLOTS), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)) fwd_i (
        .wr_i(wr), .dst_i(slot_dst_i), .new_i(new_preg),
        .src1_i(slot_src1_i), .src2_i(slot_src2_i),
        .map_src1_i(m_src1), .map_src2_i(m_src2), .map_dst_i(m_dst),
        .src1_o(ren_src1_o), .src2_o(ren_src2_o), .old_o(ren_old_o)
    );

    assign ren_dst_o = new_preg;
endmodule

// File: rtl/bundle_renamer_chk.sv
// bundle_renamer_chk: port-level properties of the renamer, bound to the top.
// Assumes: distinct, non-zero free entries and fl_avail_i <= SLOTS.
module bundle_renamer_chk #(
    parameter int SLOTS  = rnm_pkg::DEF_SLOTS,
    parameter int ARCH_W = 5,
    parameter int PHYS_W = 6,
    parameter int CNT_W  = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         flush_i,
    input logic [SLOTS-1:0]             slot_vld_i,
    input logic [SLOTS-1:0][ARCH_W-1:0] slot_src1_i,
    input logic [SLOTS-1:0][ARCH_W-1:0] slot_dst_i,
    input logic [SLOTS-1:0]             slot_hasdst_i,
    input logic [CNT_W-1:0]             fl_avail_i,
    input logic [CNT_W-1:0]             fl_pop_o,
    input logic                         stall_o,
    input logic [SLOTS-1:0][PHYS_W-1:0] ren_src1_o,
    input logic [SLOTS-1:0][PHYS_W-1:0] ren_dst_o,
    input logic [SLOTS-1:0][PHYS_W-1:0] ren_old_o
);
    logic w0, w1;
    assign w0 = slot_vld_i[0] && slot_hasdst_i[0] && slot_dst_i[0] != '0;
    assign w1 = slot_vld_i[1] && slot_hasdst_i[1] && slot_dst_i[1] != '0;

    AST_POP_LE_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        fl_pop_o <= fl_avail_i);                                          // R2
    AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> fl_pop_o == '0);                                      // R2
    AST_FLUSH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> stall_o);                                             // R10
    AST_DST_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (w0 && w1) |-> ren_dst_o[0] != ren_dst_o[1]);                     // R3
    AST_FWD_NEAREST: assert property (@(posedge clk) disable iff (!rst_n)
        (w0 && slot_src1_i[1] == slot_dst_i[0]) |-> ren_src1_o[1] == ren_dst_o[0]); // R5
    AST_OLD_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (w0 && w1 && slot_dst_i[1] == slot_dst_i[0]) |-> ren_old_o[1] == ren_dst_o[0]); // R7

    for (genvar s = 0; s < SLOTS; s++) begin : g_zero
        AST_SRC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            slot_src1_i[s] == '0 |-> ren_src1_o[s] == '0);               // R9
    end
endmodule

bind bundle_renamer bundle_renamer_chk #(
    .SLOTS(SLOTS), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .slot_vld_i(slot_vld_i),
    .slot_src1_i(slot_src1_i), .slot_dst_i(slot_dst_i),
    .slot_hasdst_i(slot_hasdst_i), .fl_avail_i(fl_avail_i),
    .fl_pop_o(fl_pop_o), .stall_o(stall_o), .ren_src1_o(ren_src1_o),
    .ren_dst_o(ren_dst_o), .ren_old_o(ren_old_o)
);

// File: tb/bundle_renamer_tb_top.sv
// Directed bench for bundle_renamer: one task per scenario, each self-checked.
module bundle_renamer_tb_top;
    localparam int SL = 4;
    localparam int AW = 5;
    localparam int PW = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 flush_i = 1'b0;
    logic [31:0][PW-1:0]  cmt_map_i = '0;
    logic [SL-1:0]        slot_vld_i = '0;
    logic [SL-1:0][AW-1:0] slot_src1_i = '0, slot_src2_i = '0, slot_dst_i = '0;
    logic [SL-1:0]        slot_hasdst_i = '0;
    logic [SL-1:0][PW-1:0] fl_free_i = '0;
    logic [2:0]           fl_avail_i = '0;
    logic [2:0]           fl_pop_o;
    logic                 stall_o;
    logic [SL-1:0][PW-1:0] ren_src1_o, ren_src2_o, ren_dst_o, ren_old_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    bundle_renamer dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .cmt_map_i(cmt_map_i),
        .slot_vld_i(slot_vld_i), .slot_src1_i(slot_src1_i),
        .slot_src2_i(slot_src2_i), .slot_dst_i(slot_dst_i),
        .slot_hasdst_i(slot_hasdst_i), .fl_free_i(fl_free_i),
        .fl_avail_i(fl_avail_i), .fl_pop_o(fl_pop_o), .stall_o(stall_o),
        .ren_src1_o(ren_src1_o), .ren_src2_o(ren_src2_o),
        .ren_dst_o(ren_dst_o), .ren_old_o(ren_old_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_bundle();
        slot_vld_i = '0; slot_src1_i = '0; slot_src2_i = '0;
        slot_dst_i = '0; slot_hasdst_i = '0; flush_i = 1'b0;
    endtask

    task automatic set_slot(input int i, input int s1, input int s2,
                            input int d, input bit hd);
        slot_vld_i[i] = 1'b1; slot_src1_i[i] = AW'(s1); slot_src2_i[i] = AW'(s2);
        slot_dst_i[i] = AW'(d); slot_hasdst_i[i] = hd;
    endtask

    task automatic set_free(input int base, input int avail);
        for (int k = 0; k < SL; k++) fl_free_i[k] = PW'(base + k);
        fl_avail_i = 3'(avail);
    endtask

    // Read one mapping through slot 0's first source with no writers.
    task automatic probe(input int areg, input int exp, input string req);
        @(negedge clk);
        clear_bundle();
        set_slot(0, areg, 0, 0, 1'b0);
        #1;
        check(req, int'(ren_src1_o[0]), exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        clear_bundle(); set_free(40, 4);
        set_slot(0, 5, 31, 0, 1'b0);
        #1;
        check("R1 src1 identity", int'(ren_src1_o[0]), 5);
        check("R1 src2 identity", int'(ren_src2_o[0]), 31);
        check("R4 no stall", int'(stall_o), 0);
        check("R11 no pop", int'(fl_pop_o), 0);
    endtask

    task automatic t_alloc();
        @(negedge clk);
        clear_bundle(); set_free(40, 4);
        set_slot(0, 1, 2, 3, 1'b1);
        set_slot(1, 4, 5, 6, 1'b0);
        set_slot(2, 1, 2, 7, 1'b1);
        set_slot(3, 1, 2, 9, 1'b1);
        #1;
        check("R3 dst slot0", int'(ren_dst_o[0]), 40);
        check("R3 dst slot2", int'(ren_dst_o[2]), 41);
        check("R3 dst slot3", int'(ren_dst_o[3]), 42);
        check("R3 pop count", int'(fl_pop_o), 3);
        check("R8 old slot0", int'(ren_old_o[0]), 3);
        check("R8 old slot3", int'(ren_old_o[3]), 9);
        probe(3, 40, "R6 r3 updated");
        probe(7, 41, "R6 r7 updated");
        probe(9, 42, "R6 r9 updated");
    endtask

    task automatic t_fwd();
        @(negedge clk);
        clear_bundle(); set_free(44, 4);
        set_slot(0, 3, 0, 10, 1'b1);
        set_slot(1, 10, 0, 10, 1'b1);
        set_slot(2, 10, 9, 0, 1'b0);
        set_slot(3, 10, 3, 11, 1'b1);
        #1;
        check("R4 map read r3", int'(ren_src1_o[0]), 40);
        check("R5 fwd slot1", int'(ren_src1_o[1]), 44);
        check("R9 src zero", int'(ren_src2_o[1]), 0);
        check("R5 nearest slot2", int'(ren_src1_o[2]), 45);
        check("R4 map read r9", int'(ren_src2_o[2]), 42);
        check("R5 nearest slot3", int'(ren_src1_o[3]), 45);
        check("R7 old chain", int'(ren_old_o[1]), 44);
        check("R8 old first", int'(ren_old_o[0]), 10);
        check("R3 dst slot3", int'(ren_dst_o[3]), 46);
        probe(10, 45, "R7 last writer kept");
        probe(11, 46, "R6 r11 updated");
    endtask

    task automatic t_stall();
        @(negedge clk);
        clear_bundle(); set_free(50, 2);
        set_slot(0, 1, 1, 12, 1'b1);
        set_slot(1, 1, 1, 13, 1'b1);
        set_slot(2, 1, 1, 14, 1'b1);
        #1;
        check("R2 stall", int'(stall_o), 1);
        check("R2 pop zero", int'(fl_pop_o), 0);
        probe(12, 12, "R2 map unchanged");
    endtask

    task automatic t_zero();
        @(negedge clk);
        clear_bundle(); set_free(50, 4);
        set_slot(0, 0, 0, 0, 1'b1);
        set_slot(1, 0, 3, 13, 1'b1);
        #1;
        check("R9 dst0 no alloc", int'(ren_dst_o[1]), 50);
        check("R9 pop one", int'(fl_pop_o), 1);
        check("R9 src zero", int'(ren_src1_o[1]), 0);
        probe(0, 0, "R9 r0 stays zero");
        probe(13, 50, "R6 r13 updated");
    endtask

    task automatic t_invalid();
        @(negedge clk);
        clear_bundle(); set_free(55, 4);
        set_slot(0, 1, 1, 14, 1'b1);
        slot_vld_i[0] = 1'b0;
        #1;
        check("R11 no pop", int'(fl_pop_o), 0);
        probe(14, 14, "R11 map unchanged");
    endtask

    task automatic t_flush();
        @(negedge clk);
        clear_bundle(); set_free(58, 4);
        for (int a = 0; a < 32; a++) cmt_map_i[a] = PW'(a + 32);
        flush_i = 1'b1;
        set_slot(0, 1, 1, 15, 1'b1);
        #1;
        check("R10 stall", int'(stall_o), 1);
        check("R10 pop zero", int'(fl_pop_o), 0);
        probe(15, 47, "R10 r15 loaded");
        probe(10, 42, "R10 r10 loaded");
        probe(1, 33, "R10 r1 loaded");
        probe(0, 0, "R10 r0 forced");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_alloc();
        t_fwd();
        t_stall();
        t_zero();
        t_invalid();
        t_flush();
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule